// File: doc/BRIEF.md
# Clock Generator Lock Status Register

This block holds the status and control byte of a clock generator that contains a frequency-locked loop and a phase-locked loop. It follows a lock detector that gives single-cycle "acquired" and "out of tolerance" pulses and reports whether the active loop is locked. It keeps a sticky loss-of-lock flag that software clears by writing 1 to it, and it can raise an interrupt from that flag. It also shows delayed copies of the reference-select, loop-select, clock-mode and oscillator-ready signals after they cross into the register clock domain.

Lock tracking is a four-state machine. LK_OFF means detection is disabled because both loops are off. LK_ACQ means the block waits for an "acquired" pulse. LK_LOCKED means the loop holds lock. LK_HOLD means a bypassed low-power mode is active. The transitions are as follows. The enable transition goes from LK_OFF to LK_ACQ, or to LK_HOLD if low power is active. The lock transition goes from LK_ACQ to LK_LOCKED on an acquired pulse. The relock transition goes from LK_LOCKED to LK_ACQ on a watched configuration change, on stop entry or on an out-of-tolerance pulse. The sleep transition goes from LK_ACQ or LK_LOCKED to LK_HOLD when low power starts. The wake transition goes from LK_HOLD to LK_ACQ when low power ends. The disable transition goes from any state to LK_OFF when both loops are off.

Status byte layout, MSB first: loss-of-lock flag, lock, loop-select status, internal-reference status, two clock-mode bits, oscillator-ready status, fine-trim bit.

Top module: `clkgen_lock_status`

## Requirements
- R1: After reset, `status` is 8'h00 and `lol_irq` is 0.
- R2: While detection is enabled (`fll_en` or `pll_en` is 1), an `lk_acquired` pulse in LK_ACQ sets `status[6]` one clock later.
- R3: When `fll_en` and `pll_en` are both 0, `status[6]` is 0 one clock later, and `lk_acquired` pulses have no effect.
- R4: A change of `ref_int_sel`, `loop_pll_sel` or `ref_div` while locked clears `status[6]` one clock later. The bit stays 0 until a new `lk_acquired` pulse arrives.
- R5: A change of `trim` clears lock only while `fll_int_mode` is 1. A change of `vco_div` clears lock only while `pll_ext_mode` is 1. Otherwise these changes have no effect.
- R6: A rising edge of `stop_req` clears `status[6]` one clock later. A later `lk_acquired` pulse sets it again.
- R7: While `blp_mode` is 1, `status[6]` is 0 and `lk_acquired` pulses are ignored. After `blp_mode` falls, a new pulse relocks.
- R8: An `lk_out_of_tol` pulse while locked sets `status[7]` and clears `status[6]` one clock later. The same pulse while unlocked, or before the first lock, leaves `status[7]` at 0.
- R9: A write (`wr_en`=1) with `wr_data[7]`=1 clears `status[7]` one clock later. A write with `wr_data[7]`=0 leaves it set. A loss-of-lock event in the same cycle as the clearing write wins.
- R10: `lol_irq` equals `status[7]` AND `lol_irq_en`.
- R11: `status[5]`=`loop_pll_sel`, `status[4]`=`ref_int_sel`, `status[3:2]`=`clk_mode_sel` and `status[1]`=`osc_ready`, each after two register clock edges and unchanged after only one. The clock-mode code is 00 for FLL output, 01 for the internal reference, 10 for the external reference and 11 for PLL output.
- R12: A write loads `wr_data[0]` into `status[0]` one clock later. The write leaves `status[6:1]` unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fll_en | input | 1 | FLL enabled |
| pll_en | input | 1 | PLL enabled |
| fll_int_mode | input | 1 | FLL running from internal reference (trim watched) |
| pll_ext_mode | input | 1 | PLL running from external reference (VCO divider watched) |
| ref_int_sel | input | 1 | Reference select control, 1 = internal |
| loop_pll_sel | input | 1 | Loop select control, 1 = PLL |
| clk_mode_sel | input | 2 | Clock mode select control |
| ref_div | input | RDIV_W (3) | Reference divider |
| trim | input | TRIM_W (8) | Internal reference trim |
| vco_div | input | VDIV_W (4) | VCO divider |
| osc_ready | input | 1 | Oscillator initialized, other domain |
| stop_req | input | 1 | Stop mode active |
| blp_mode | input | 1 | Bypassed low-power mode active |
| lk_acquired | input | 1 | Lock detector: lock acquired pulse |
| lk_out_of_tol | input | 1 | Lock detector: out-of-tolerance pulse |
| lol_irq_en | input | 1 | Loss-of-lock interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| status | output | 8 | Status byte |
| lol_irq | output | 1 | Loss-of-lock interrupt request |

## Verification
The assertions take three things for granted. Lock-detector events are single-cycle pulses, never high together. All inputs change only between clock edges. Reset is held low with every input at 0, so the synchronizer stages start from known values. The stimulus drives every input on the falling clock edge, and it raises each lock-detector pulse for exactly one cycle. It also changes one watched control at a time, so the cause of each lock-state change is clear.

// File: rtl/clkstat_pkg.sv
package clkstat_pkg;
    typedef enum logic [1:0] {
        LK_OFF    = 2'd0,
        LK_ACQ    = 2'd1,
        LK_LOCKED = 2'd2,
        LK_HOLD   = 2'd3
    } lk_state_t;

    localparam int STAT_W   = 8;
    localparam int B_LOL    = 7;
    localparam int B_LOCK   = 6;
    localparam int B_PLLST  = 5;
    localparam int B_IREFST = 4;
    localparam int B_CLKLO  = 2;
    localparam int B_OSC    = 1;
    localparam int B_FTRIM  = 0;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cs_cfg_watch.sv
module cs_cfg_watch #(
    parameter int RDIV_W = 3,
    parameter int TRIM_W = 8,
    parameter int VDIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_int_sel,
    input  logic              loop_pll_sel,
    input  logic [RDIV_W-1:0] ref_div,
    input  logic [TRIM_W-1:0] trim,
    input  logic [VDIV_W-1:0] vco_div,
    input  logic              fll_int_mode,
    input  logic              pll_ext_mode,
    output logic              cfg_chg
);
    logic              prev_vld;
    logic              ref_q, loop_q;
    logic [RDIV_W-1:0] rdiv_q;
    logic [TRIM_W-1:0] trim_q;
    logic [VDIV_W-1:0] vdiv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_vld <= 1'b0;
            ref_q    <= 1'b0;
            loop_q   <= 1'b0;
            rdiv_q   <= '0;
            trim_q   <= '0;
            vdiv_q   <= '0;
        end else begin
            prev_vld <= 1'b1;
            ref_q    <= ref_int_sel;
            loop_q   <= loop_pll_sel;
            rdiv_q   <= ref_div;
            trim_q   <= trim;
            vdiv_q   <= vco_div;
        end
    end

    always_comb begin
        cfg_chg = prev_vld && ((ref_int_sel != ref_q)
                            || (loop_pll_sel != loop_q)
                            || (ref_div != rdiv_q)
                            || (fll_int_mode && (trim != trim_q))
                            || (pll_ext_mode && (vco_div != vdiv_q)));
    end
endmodule

// File: rtl/cs_lock_fsm.sv
module cs_lock_fsm
    import clkstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic acq,
    input  logic oot,
    input  logic cfg_chg,
    input  logic stop_req,
    input  logic blp,
    output logic locked,
    output logic lol_set
);
    lk_state_t st, nxt;
    logic      stop_q;
    logic      stop_entry;

    assign stop_entry = stop_req && !stop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= LK_OFF;
            stop_q <= 1'b0;
        end else begin
            st     <= nxt;
            stop_q <= stop_req;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            LK_OFF: begin
                if (det_en) nxt = blp ? LK_HOLD : LK_ACQ;
            end
            LK_ACQ: begin
                if (!det_en)                              nxt = LK_OFF;
                else if (blp)                             nxt = LK_HOLD;
                else if (acq && !cfg_chg && !stop_entry)  nxt = LK_LOCKED;
            end
            LK_LOCKED: begin
                if (!det_en)                              nxt = LK_OFF;
                else if (blp)                             nxt = LK_HOLD;
                else if (cfg_chg || stop_entry || oot)    nxt = LK_ACQ;
            end
            LK_HOLD: begin
                if (!det_en)                              nxt = LK_OFF;
                else if (!blp)                            nxt = LK_ACQ;
            end
            default: nxt = LK_OFF;
        endcase
    end

    always_comb begin
        locked  = (st == LK_LOCKED);
        lol_set = (st == LK_LOCKED) && det_en && oot;
    end
endmodule

// File: rtl/clkgen_lock_status.sv
module clkgen_lock_status
    import clkstat_pkg::*;
#(
    parameter int RDIV_W      = 3,
    parameter int TRIM_W      = 8,
    parameter int VDIV_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fll_en,
    input  logic              pll_en,
    input  logic              fll_int_mode,
    input  logic              pll_ext_mode,
    input  logic              ref_int_sel,
    input  logic              loop_pll_sel,
    input  logic [1:0]        clk_mode_sel,
    input  logic [RDIV_W-1:0] ref_div,
    input  logic [TRIM_W-1:0] trim,
    input  logic [VDIV_W-1:0] vco_div,
    input  logic              osc_ready,
    input  logic              stop_req,
    input  logic              blp_mode,
    input  logic              lk_acquired,
    input  logic              lk_out_of_tol,
    input  logic              lol_irq_en,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              lol_irq
);
    localparam int MIR_W = 5;

    logic             cfg_chg, locked, lol_set;
    logic             lol_flag, ftrim_q;
    logic [MIR_W-1:0] mir_d, mir_q;
    logic             wr_unused;

    assign wr_unused = ^wr_data[B_LOCK:B_OSC];

    cs_cfg_watch #(.RDIV_W(RDIV_W), .TRIM_W(TRIM_W), .VDIV_W(VDIV_W)) u_watch (
        .clk(clk), .rst_n(rst_n),
        .ref_int_sel(ref_int_sel), .loop_pll_sel(loop_pll_sel),
        .ref_div(ref_div), .trim(trim), .vco_div(vco_div),
        .fll_int_mode(fll_int_mode), .pll_ext_mode(pll_ext_mode),
        .cfg_chg(cfg_chg)
    );

    cs_lock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .det_en(fll_en || pll_en),
        .acq(lk_acquired), .oot(lk_out_of_tol),
        .cfg_chg(cfg_chg), .stop_req(stop_req), .blp(blp_mode),
        .locked(locked), .lol_set(lol_set)
    );

    assign mir_d = {loop_pll_sel, ref_int_sel, clk_mode_sel, osc_ready};

    cs_sync #(.W(MIR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(mir_d), .q(mir_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lol_flag <= 1'b0;
            ftrim_q  <= 1'b0;
        end else begin
            if (lol_set)
                lol_flag <= 1'b1;
            else if (wr_en && wr_data[B_LOL])
                lol_flag <= 1'b0;
            if (wr_en)
                ftrim_q <= wr_data[B_FTRIM];
        end
    end

    always_comb begin
        status          = '0;
        status[B_LOL]   = lol_flag;
        status[B_LOCK]  = locked;
        status[B_PLLST:B_OSC] = mir_q;
        status[B_FTRIM] = ftrim_q;
        lol_irq         = lol_flag && lol_irq_en;
    end
endmodule

// File: rtl/clkgen_lock_status_chk.sv
module clkgen_lock_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fll_en,
    input logic       pll_en,
    input logic       blp_mode,
    input logic       lk_acquired,
    input logic       lk_out_of_tol,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] status
);
    logic det;
    assign det = fll_en || pll_en;

    a_r2_lock_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> $past(lk_acquired));

    a_r3_off_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !det |=> !status[6]);

    a_r7_lowpower_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        blp_mode |=> !status[6]);

    a_r8_lol_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && lk_out_of_tol && det) |=> (status[7] && !status[6]));

    a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && wr_en && wr_data[7] && !(status[6] && lk_out_of_tol && det))
        |=> !status[7]);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !(wr_en && wr_data[7])) |=> status[7]);
endmodule

bind clkgen_lock_status clkgen_lock_status_chk chk_i (
    .clk(clk), .rst_n(rst_n), .fll_en(fll_en), .pll_en(pll_en),
    .blp_mode(blp_mode), .lk_acquired(lk_acquired),
    .lk_out_of_tol(lk_out_of_tol), .wr_en(wr_en), .wr_data(wr_data),
    .status(status)
);

// File: tb/clkgen_lock_status_tb_top.sv
module clkgen_lock_status_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fll_en = 0, pll_en = 0, fll_int_mode = 0, pll_ext_mode = 0;
    logic       ref_int_sel = 0, loop_pll_sel = 0;
    logic [1:0] clk_mode_sel = 0;
    logic [2:0] ref_div = 0;
    logic [7:0] trim = 0;
    logic [3:0] vco_div = 0;
    logic       osc_ready = 0, stop_req = 0, blp_mode = 0;
    logic       lk_acquired = 0, lk_out_of_tol = 0, lol_irq_en = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] status;
    logic       lol_irq;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;

    typedef struct {
        int         at;
        logic [7:0] m;
        logic [7:0] v;
        bit         ci;
        bit         iv;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    clkgen_lock_status dut_i (
        .clk(clk), .rst_n(rst_n), .fll_en(fll_en), .pll_en(pll_en),
        .fll_int_mode(fll_int_mode), .pll_ext_mode(pll_ext_mode),
        .ref_int_sel(ref_int_sel), .loop_pll_sel(loop_pll_sel),
        .clk_mode_sel(clk_mode_sel), .ref_div(ref_div), .trim(trim),
        .vco_div(vco_div), .osc_ready(osc_ready), .stop_req(stop_req),
        .blp_mode(blp_mode), .lk_acquired(lk_acquired),
        .lk_out_of_tol(lk_out_of_tol), .lol_irq_en(lol_irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .status(status), .lol_irq(lol_irq)
    );

    // monitor: compares outputs at falling edges against queued expectations
    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].at <= cyc) begin
            e = q.pop_front();
            n_chk++;
            if ((status & e.m) != e.v) begin
                n_err++;
                $display("FAIL %s: status&%h = %h, expected %h", e.tag, e.m, status & e.m, e.v);
            end
            if (e.ci) begin
                n_chk++;
                if (lol_irq != e.iv) begin
                    n_err++;
                    $display("FAIL %s: lol_irq = %0b, expected %0b", e.tag, lol_irq, e.iv);
                end
            end
        end
    end

    task automatic expect_st(int d, logic [7:0] m, logic [7:0] v, bit ci, bit iv, string tag);
        q.push_back('{cyc + d, m, v, ci, iv, tag});
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_acq(bit lk, string tag);
        @(negedge clk);
        lk_acquired = 1'b1;
        expect_st(1, 8'h40, lk ? 8'h40 : 8'h00, 0, 0, tag);
        @(negedge clk);
        lk_acquired = 1'b0;
    endtask

    task automatic pulse_oot(bit lol, bit irq_chk, bit irq, string tag);
        @(negedge clk);
        lk_out_of_tol = 1'b1;
        expect_st(1, 8'hC0, lol ? 8'h80 : 8'h00, irq_chk, irq, tag);
        @(negedge clk);
        lk_out_of_tol = 1'b0;
    endtask

    task automatic wr(logic [7:0] d, logic [7:0] m, logic [7:0] v, string tag);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        expect_st(1, m, v, 0, 0, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_st(1, 8'hFF, 8'h00, 1, 0, "R1 reset state");
        step(2);

        fll_en = 1'b1;
        step(1);
        pulse_oot(0, 0, 0, "R8 oot before first lock");
        pulse_acq(1, "R2 lock acquired");

        // R4: reference divider and loop select changes
        @(negedge clk); ref_div = 3'd3;
        expect_st(1, 8'h40, 8'h00, 0, 0, "R4 ref_div clears lock");
        expect_st(3, 8'h40, 8'h00, 0, 0, "R4 stays unlocked");
        step(3);
        pulse_oot(0, 0, 0, "R8 oot while unlocked");
        pulse_acq(1, "R4 relock");
        @(negedge clk); loop_pll_sel = 1'b1;
        expect_st(1, 8'h40, 8'h00, 0, 0, "R4 loop select clears lock");
        step(2);
        pulse_acq(1, "R4 relock 2");

        // R5: mode-qualified fields
        @(negedge clk); trim = 8'h5A;
        expect_st(1, 8'h40, 8'h40, 0, 0, "R5 trim ignored");
        @(negedge clk); fll_int_mode = 1'b1;
        @(negedge clk); trim = 8'hA5;
        expect_st(1, 8'h40, 8'h00, 0, 0, "R5 trim clears in FLL internal");
        pulse_acq(1, "R5 relock");
        @(negedge clk); fll_int_mode = 1'b0; vco_div = 4'd9;
        expect_st(1, 8'h40, 8'h40, 0, 0, "R5 vco_div ignored");
        @(negedge clk); pll_ext_mode = 1'b1;
        @(negedge clk); vco_div = 4'd2;
        expect_st(1, 8'h40, 8'h00, 0, 0, "R5 vco_div clears in PLL external");
        pulse_acq(1, "R5 relock 2");
        @(negedge clk); pll_ext_mode = 1'b0;

        // R6: stop entry
        @(negedge clk); stop_req = 1'b1;
        expect_st(1, 8'h40, 8'h00, 0, 0, "R6 stop entry clears lock");
        pulse_acq(1, "R6 relock");
        @(negedge clk); stop_req = 1'b0;

        // R7: bypassed low power
        @(negedge clk); blp_mode = 1'b1;
        expect_st(1, 8'h40, 8'h00, 0, 0, "R7 low power clears lock");
        pulse_acq(0, "R7 acquire ignored in low power");
        @(negedge clk); blp_mode = 1'b0;
        pulse_acq(1, "R7 relock after exit");

        // R8 / R10
        pulse_oot(1, 1, 0, "R8 R10 loss of lock, irq masked");
        @(negedge clk); lol_irq_en = 1'b1;
        expect_st(1, 8'h80, 8'h80, 1, 1, "R10 irq raised");

        // R9
        wr(8'h00, 8'h80, 8'h80, "R9 write 0 no effect");
        pulse_acq(1, "R9 relock");
        @(negedge clk);
        lk_out_of_tol = 1'b1; wr_en = 1'b1; wr_data = 8'h80;
        expect_st(1, 8'hC0, 8'h80, 1, 1, "R9 set wins over clear");
        @(negedge clk);
        lk_out_of_tol = 1'b0; wr_en = 1'b0;
        wr(8'h80, 8'h80, 8'h00, "R9 write 1 clears");
        expect_st(1, 8'h00, 8'h00, 1, 0, "R10 irq drops");
        step(1);

        // R3
        pulse_acq(1, "R3 relock before disable");
        @(negedge clk); fll_en = 1'b0;
        expect_st(1, 8'h40, 8'h00, 0, 0, "R3 disabled unlocks");
        pulse_acq(0, "R3 acquire ignored when disabled");

        // R11: mirrored fields (loop=1 currently, others 0)
        @(negedge clk);
        clk_mode_sel = 2'b11; ref_int_sel = 1'b1; loop_pll_sel = 1'b0; osc_ready = 1'b1;
        expect_st(1, 8'h3E, 8'h20, 0, 0, "R11 unchanged after one edge");
        expect_st(2, 8'h3E, 8'h1E, 0, 0, "R11 mirrored after two edges");
        step(3);
        @(negedge clk);
        clk_mode_sel = 2'b01; ref_int_sel = 1'b0; loop_pll_sel = 1'b1; osc_ready = 1'b0;
        expect_st(1, 8'h3E, 8'h1E, 0, 0, "R11 pattern B one edge");
        expect_st(2, 8'h3E, 8'h24, 0, 0, "R11 pattern B two edges");
        step(3);

        // R12
        wr(8'h01, 8'hFF, 8'h25, "R12 fine trim set");
        wr(8'hFE, 8'hFF, 8'h24, "R12 fine trim cleared, others kept");

        step(4);
        if (q.size() != 0) begin
            n_err++;
            $display("FAIL drain: %0d pending, expected 0", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule